// File: doc/BRIEF.md
# Legacy Virtqueue Register Interface

This block is the port-mapped register file that sits in front of a legacy paravirtual device with a small set of virtqueues. Driver software reads the feature word the device offers, writes back the features it accepts, selects a queue, hands over the physical page frame of that queue's ring, kicks queues through a notify register, moves the device through its status byte and acknowledges interrupts by reading the interrupt status byte. The block turns those accesses into stored state and short pulses for the queue engines: a ring-init pulse, a notify pulse per queue, a driver-ready pulse and a device-reset pulse.

When a page frame is programmed, the block computes the three ring base addresses (descriptor table, available ring, used ring) once and holds them on its outputs. Accesses at or above the device-specific region are passed straight through to an external configuration port. Reads return data in the same cycle; every side effect takes place at the clock edge that ends the access.

Top module: `vq_legacy_regs`

## Requirements
- R1: A read of the host feature word (offset 0x00) returns `dev_features` with bit 24 (notify-on-empty) and bit 30 (negotiation-failure marker) forced to one.
- R2: A write of the guest feature word (offset 0x04) whose set bits all lie in the offered set (`dev_features` with bit 24 set) is stored unchanged; it appears on `guest_features` and reads back from offset 0x04.
- R3: A guest feature write that has a bit outside the offered set and has bit 30 set stores `min_features` instead.
- R4: A guest feature write that has a bit outside the offered set and has bit 30 clear stores the written value ANDed with the offered set.
- R5: A write to the queue selector (offset 0x0E) uses only its low 16 bits and is accepted only when that value is below `NQ`; otherwise the selector keeps its value. Reads of 0x0E return the selector.
- R6: A nonzero write to the page-frame register (offset 0x08) stores the frame for the selected queue, pulses that queue's `ring_init` bit for one cycle, and sets descriptor base = frame × 4096, available base = descriptor base + 16 × `QSIZE`, used base = (available base + 4 + 2 × `QSIZE`) rounded up to a multiple of 4096. Offset 0x08 reads the selected queue's frame; offset 0x0C reads `QSIZE`.
- R7: Writing zero to the page-frame register or to the status byte (offset 0x12) pulses `dev_reset` for one cycle and clears guest features, selector, status, interrupt status and every queue's frame and bases; `bus_master_en` is not changed.
- R8: A status write takes the low 8 bits; when it sets bit 2 (driver ready) while the stored status has bit 2 clear, `drv_ready` pulses for one cycle and `bus_master_en` becomes one and stays one until `rst_n`.
- R9: A read of the interrupt status byte (offset 0x13) returns its current value and clears it; `irq` is one exactly while the byte is nonzero. Bits of `isr_set` are ORed into the byte at each clock edge.
- R10: A write to the notify register (offset 0x10) whose low 16 bits name a queue below `NQ` with a nonzero descriptor base pulses that queue's `q_notify` bit for one cycle; any other notify write changes no output.
- R11: Read data is zero-extended to the access size given by `bus_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and write data is truncated to it; reads of unmapped offsets below 0x14 return all ones within that size.
- R12: Accesses at offset 0x14 and above drive `cfg_wr` or `cfg_rd` in the same cycle with `cfg_addr` = offset − 0x14, `cfg_size` and `cfg_wdata` copied, and the read returns `cfg_rdata`.
- R13: When an interrupt status read and a nonzero `isr_set` fall in the same cycle, the read returns the old byte and the new bits survive the clear.
- R14: After `rst_n` low, guest features, selector, status, interrupt status, all frames and bases are zero, and `irq`, `bus_master_en` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| dev_features | input | 32 | Features the device offers |
| min_features | input | 32 | Fallback feature set after failed negotiation |
| isr_set | input | 8 | Interrupt cause bits to OR into the status byte |
| guest_features | output | 32 | Accepted feature word |
| irq | output | 1 | Interrupt line |
| dev_reset | output | 1 | One-cycle device reset pulse |
| drv_ready | output | 1 | One-cycle driver-ready pulse |
| bus_master_en | output | 1 | Bus mastering enable |
| q_notify | output | NQ | Per-queue notify pulses |
| ring_init | output | NQ | Per-queue ring (re)start pulses |
| desc_base | output | NQ×PA_W | Descriptor table bases, queue 0 lowest |
| avail_base | output | NQ×PA_W | Available ring bases |
| used_base | output | NQ×PA_W | Used ring bases |
| cfg_wr | output | 1 | Device region write strobe |
| cfg_rd | output | 1 | Device region read strobe |
| cfg_addr | output | 8 | Offset within the device region |
| cfg_size | output | 2 | Access size to the device region |
| cfg_wdata | output | 32 | Write data to the device region |
| cfg_rdata | input | 32 | Read data from the device region |

## Verification
The collision that matters here is an interrupt status read landing in the same cycle as a new interrupt cause: the clear-on-read and the set both update the same byte at one edge. The bench raises one cause, then drives a second cause together with the status read, expects the read to return only the first cause, expects `irq` to stay high afterwards, and expects a follow-up read to return only the second cause. The soft reset path is also driven while a cause is pending, to show the reset clears it and that `bus_master_en` survives.

// File: rtl/vq_regs_pkg.sv
// Shared offsets, bit positions and ring layout constants for the
// legacy virtqueue register interface. Assumes an 8-bit byte offset bus.
package vq_regs_pkg;

    localparam logic [7:0] OFF_HOSTF  = 8'h00;
    localparam logic [7:0] OFF_GUESTF = 8'h04;
    localparam logic [7:0] OFF_PFN    = 8'h08;
    localparam logic [7:0] OFF_QSIZE  = 8'h0C;
    localparam logic [7:0] OFF_QSEL   = 8'h0E;
    localparam logic [7:0] OFF_NOTIFY = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h12;
    localparam logic [7:0] OFF_ISR    = 8'h13;
    localparam logic [7:0] OFF_CFG    = 8'h14;

    localparam int BIT_EMPTY_NOTE = 24;
    localparam int BIT_NEG_FAIL   = 30;
    localparam int BIT_DRV_READY  = 2;

    localparam int PAGE_SHIFT  = 12;
    localparam int DESC_BYTES  = 16;
    localparam int AVAIL_HDR   = 4;
    localparam int AVAIL_ENTRY = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Byte-lane mask for an access size code.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vq_feat_negotiate.sv
// Feature negotiation: forms the advertised word and decides what a
// guest feature write turns into. Purely combinational.
module vq_feat_negotiate
    import vq_regs_pkg::*;
(
    input  logic [31:0] dev_feat,
    input  logic [31:0] min_feat,
    input  logic [31:0] req_feat,
    output logic [31:0] adv_word,
    output logic [31:0] granted
);
    logic [31:0] offered;

    // Offered set and advertised word.
    always_comb begin
        offered  = dev_feat | (32'h1 << BIT_EMPTY_NOTE);
        adv_word = offered | (32'h1 << BIT_NEG_FAIL);
    end

    // Accept, fall back, or mask a requested feature word.
    always_comb begin
        if ((req_feat & ~offered) == 32'h0)
            granted = req_feat;
        else if (req_feat[BIT_NEG_FAIL])
            granted = min_feat;
        else
            granted = req_feat & offered;
    end
endmodule

// File: rtl/vq_ring_calc.sv
// Ring layout calculator: derives the three ring bases from a page frame.
// Assumes one fixed ring size for every queue.
module vq_ring_calc
    import vq_regs_pkg::*;
#(
    parameter int PFN_W = 32,
    parameter int PA_W  = 44,
    parameter int QSIZE = 256
) (
    input  logic [PFN_W-1:0] pfn,
    output logic [PA_W-1:0]  desc,
    output logic [PA_W-1:0]  avail,
    output logic [PA_W-1:0]  used
);
    localparam logic [PA_W-1:0] PG_LOW   = PA_W'((1 << PAGE_SHIFT) - 1);
    localparam logic [PA_W-1:0] DESC_LEN = PA_W'(DESC_BYTES * QSIZE);
    localparam logic [PA_W-1:0] AV_LEN   = PA_W'(AVAIL_HDR + AVAIL_ENTRY * QSIZE);

    logic [PA_W-1:0] av_end;

    // Descriptor table, available ring, then page-aligned used ring.
    always_comb begin
        desc   = PA_W'(pfn) << PAGE_SHIFT;
        avail  = desc + DESC_LEN;
        av_end = avail + AV_LEN;
        used   = (av_end + PG_LOW) & ~PG_LOW;
    end
endmodule

// File: rtl/vq_queue_bank.sv
// Per-queue storage of page frame and ring bases. A load writes one queue;
// a clear wipes all queues. Assumes load and clear are never both set for
// the same queue in a way that matters (clear wins).
module vq_queue_bank #(
    parameter int NQ    = 2,
    parameter int PFN_W = 32,
    parameter int PA_W  = 44
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic [NQ-1:0]             load,
    input  logic [PFN_W-1:0]          ld_pfn,
    input  logic [PA_W-1:0]           ld_desc,
    input  logic [PA_W-1:0]           ld_avail,
    input  logic [PA_W-1:0]           ld_used,
    output logic [NQ-1:0][PFN_W-1:0]  pfn_q,
    output logic [NQ-1:0][PA_W-1:0]   desc_q,
    output logic [NQ-1:0][PA_W-1:0]   avail_q,
    output logic [NQ-1:0][PA_W-1:0]   used_q
);
    for (genvar g = 0; g < NQ; g++) begin : g_q
        // Hold or replace this queue's frame and bases.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pfn_q[g]   <= '0;
                desc_q[g]  <= '0;
                avail_q[g] <= '0;
                used_q[g]  <= '0;
            end else if (load[g]) begin
                pfn_q[g]   <= ld_pfn;
                desc_q[g]  <= ld_desc;
                avail_q[g] <= ld_avail;
                used_q[g]  <= ld_used;
            end
        end
    end
endmodule

// File: rtl/vq_legacy_regs.sv
// Legacy virtqueue register file. Decodes single-cycle register accesses,
// returns read data combinationally and applies every side effect at the
// closing clock edge. Assumes bus_wr and bus_rd are not asserted together.
module vq_legacy_regs
    import vq_regs_pkg::*;
#(
    parameter int NQ    = 2,
    parameter int PFN_W = 32,
    parameter int QSIZE = 256,
    localparam int PA_W = PFN_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [31:0]        dev_features,
    input  logic [31:0]        min_features,
    input  logic [7:0]         isr_set,
    output logic [31:0]        guest_features,
    output logic               irq,
    output logic               dev_reset,
    output logic               drv_ready,
    output logic               bus_master_en,
    output logic [NQ-1:0]      q_notify,
    output logic [NQ-1:0]      ring_init,
    output logic [NQ*PA_W-1:0] desc_base,
    output logic [NQ*PA_W-1:0] avail_base,
    output logic [NQ*PA_W-1:0] used_base,
    output logic               cfg_wr,
    output logic               cfg_rd,
    output logic [7:0]         cfg_addr,
    output logic [1:0]         cfg_size,
    output logic [31:0]        cfg_wdata,
    input  logic [31:0]        cfg_rdata
);
    localparam int SEL_W = (NQ > 1) ? $clog2(NQ) : 1;

    logic [31:0]      wdata_m, adv_word, granted, rd_raw;
    logic [SEL_W-1:0] q_sel;
    logic [7:0]       status, isr;
    logic [15:0]      idx16;
    logic             wr_guestf, wr_pfn, wr_qsel, wr_notify, wr_status, rd_isr;
    logic             soft_rst, ready_d, in_cfg;
    logic [NQ-1:0]    load, notify_d;
    logic [PA_W-1:0]  c_desc, c_avail, c_used;
    logic [NQ-1:0][PFN_W-1:0] pfn_arr;
    logic [NQ-1:0][PA_W-1:0]  desc_arr, avail_arr, used_arr;

    // Access decode and size-truncated write data.
    always_comb begin
        wdata_m   = bus_wdata & size_mask(bus_size);
        idx16     = wdata_m[15:0];
        in_cfg    = (bus_addr >= OFF_CFG);
        wr_guestf = bus_wr && (bus_addr == OFF_GUESTF);
        wr_pfn    = bus_wr && (bus_addr == OFF_PFN);
        wr_qsel   = bus_wr && (bus_addr == OFF_QSEL);
        wr_notify = bus_wr && (bus_addr == OFF_NOTIFY);
        wr_status = bus_wr && (bus_addr == OFF_STATUS);
        rd_isr    = bus_rd && (bus_addr == OFF_ISR);
        soft_rst  = (wr_pfn && wdata_m[PFN_W-1:0] == '0)
                 || (wr_status && wdata_m[7:0] == 8'h00);
        ready_d   = wr_status && wdata_m[BIT_DRV_READY] && !status[BIT_DRV_READY];
    end

    // Per-queue load and notify qualification.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            load[i]     = wr_pfn && (wdata_m[PFN_W-1:0] != '0) && (q_sel == SEL_W'(i));
            notify_d[i] = wr_notify && (idx16 == 16'(i)) && (desc_arr[i] != '0);
        end
    end

    vq_feat_negotiate u_feat (
        .dev_feat (dev_features),
        .min_feat (min_features),
        .req_feat (wdata_m),
        .adv_word (adv_word),
        .granted  (granted)
    );

    vq_ring_calc #(.PFN_W(PFN_W), .PA_W(PA_W), .QSIZE(QSIZE)) u_calc (
        .pfn   (wdata_m[PFN_W-1:0]),
        .desc  (c_desc),
        .avail (c_avail),
        .used  (c_used)
    );

    vq_queue_bank #(.NQ(NQ), .PFN_W(PFN_W), .PA_W(PA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .load     (load),
        .ld_pfn   (wdata_m[PFN_W-1:0]),
        .ld_desc  (c_desc),
        .ld_avail (c_avail),
        .ld_used  (c_used),
        .pfn_q    (pfn_arr),
        .desc_q   (desc_arr),
        .avail_q  (avail_arr),
        .used_q   (used_arr)
    );

    // Device-state registers cleared by hard or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            guest_features <= '0;
            q_sel          <= '0;
            status         <= '0;
            isr            <= '0;
        end else begin
            if (wr_guestf) guest_features <= granted;
            if (wr_qsel && idx16 < 16'(NQ)) q_sel <= idx16[SEL_W-1:0];
            if (wr_status) status <= wdata_m[7:0];
            isr <= (rd_isr ? 8'h00 : isr) | isr_set;
        end
    end

    // Output pulses and the sticky bus-master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_reset     <= 1'b0;
            drv_ready     <= 1'b0;
            bus_master_en <= 1'b0;
            q_notify      <= '0;
            ring_init     <= '0;
        end else begin
            dev_reset <= soft_rst;
            drv_ready <= ready_d;
            q_notify  <= notify_d;
            ring_init <= load;
            if (ready_d) bus_master_en <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_HOSTF:  rd_raw = adv_word;
            OFF_GUESTF: rd_raw = guest_features;
            OFF_PFN:    rd_raw = 32'(pfn_arr[q_sel]);
            OFF_QSIZE:  rd_raw = 32'(QSIZE);
            OFF_QSEL:   rd_raw = 32'(q_sel);
            OFF_STATUS: rd_raw = 32'(status);
            OFF_ISR:    rd_raw = 32'(isr);
            default:    rd_raw = in_cfg ? cfg_rdata : 32'hFFFF_FFFF;
        endcase
        bus_rdata = rd_raw & size_mask(bus_size);
    end

    // Device region pass-through and flattened outputs.
    always_comb begin
        cfg_wr     = bus_wr && in_cfg;
        cfg_rd     = bus_rd && in_cfg;
        cfg_addr   = bus_addr - OFF_CFG;
        cfg_size   = bus_size;
        cfg_wdata  = bus_wdata;
        irq        = (isr != 8'h00);
        desc_base  = desc_arr;
        avail_base = avail_arr;
        used_base  = used_arr;
    end
endmodule

// File: rtl/vq_legacy_regs_chk.sv
// Property checker for the legacy virtqueue register file, bound to it.
module vq_legacy_regs_chk
    import vq_regs_pkg::*;
#(
    parameter int NQ    = 2,
    parameter int PA_W  = 44,
    parameter int SEL_W = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_addr,
    input logic [1:0]         bus_size,
    input logic [31:0]        bus_wdata,
    input logic [7:0]         isr_set,
    input logic [31:0]        guest_features,
    input logic               irq,
    input logic               dev_reset,
    input logic               drv_ready,
    input logic               bus_master_en,
    input logic [NQ-1:0]      q_notify,
    input logic [NQ-1:0]      ring_init,
    input logic [NQ*PA_W-1:0] desc_base,
    input logic [SEL_W-1:0]   q_sel
);
    logic [15:0] sel_req;
    assign sel_req = bus_wdata[15:0] & size_mask(bus_size)[15:0];

    assert_notify_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_notify));

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assert_notify_live_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
            q_notify[g] |-> (desc_base[g*PA_W +: PA_W] != '0));
        assert_init_has_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ring_init[g] |-> (desc_base[g*PA_W +: PA_W] != '0));
    end

    assert_ready_masters_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_ready |-> bus_master_en);

    assert_soft_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (guest_features == 32'h0 && !irq && desc_base == '0));

    assert_isr_read_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFF_ISR && isr_set == 8'h00) |=> !irq);

    assert_bad_select_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_QSEL && sel_req >= 16'(NQ)) |=> $stable(q_sel));
endmodule

bind vq_legacy_regs vq_legacy_regs_chk #(.NQ(NQ), .PA_W(PA_W), .SEL_W(SEL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_size       (bus_size),
    .bus_wdata      (bus_wdata),
    .isr_set        (isr_set),
    .guest_features (guest_features),
    .irq            (irq),
    .dev_reset      (dev_reset),
    .drv_ready      (drv_ready),
    .bus_master_en  (bus_master_en),
    .q_notify       (q_notify),
    .ring_init      (ring_init),
    .desc_base      (desc_base),
    .q_sel          (q_sel)
);

// File: tb/sim_vq_legacy_regs.sv
// Scoreboard bench: driver tasks queue expected items, a monitor at each
// falling edge pops and compares them against the design's outputs.
module sim_vq_legacy_regs;
    localparam int NQ = 2, PFN_W = 32, QSIZE = 256, PA_W = PFN_W + 12;
    localparam int K_RDATA = 0, K_NOTIFY = 1, K_RESET = 2, K_READY = 3, K_IRQ = 4,
                   K_MASTER = 5, K_DESC = 6, K_AVAIL = 7, K_USED = 8, K_GUEST = 9,
                   K_CFGWR = 10, K_CFGADDR = 11, K_INIT = 12, K_CFGRD = 13;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0, isr_set = 0, cfg_addr;
    logic [1:0] bus_size = 0, cfg_size;
    logic [31:0] bus_wdata = 0, bus_rdata, guest_features, cfg_wdata;
    logic [31:0] dev_features = 32'h0000_0021, min_features = 32'h0000_0001;
    logic [31:0] cfg_rdata = 32'hCAFE_0123;
    logic irq, dev_reset, drv_ready, bus_master_en, cfg_wr, cfg_rd;
    logic [NQ-1:0] q_notify, ring_init;
    logic [NQ*PA_W-1:0] desc_base, avail_base, used_base;

    vq_legacy_regs #(.NQ(NQ), .PFN_W(PFN_W), .QSIZE(QSIZE)) u0 (.*);

    always #5 clk = ~clk;

    typedef struct { string tag; int kind; int q; logic [63:0] exp; } item_t;
    item_t sbq[$];
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    function automatic logic [63:0] sample(int k, int q);
        case (k)
            K_RDATA:   return 64'(bus_rdata);
            K_NOTIFY:  return 64'(q_notify);
            K_RESET:   return 64'(dev_reset);
            K_READY:   return 64'(drv_ready);
            K_IRQ:     return 64'(irq);
            K_MASTER:  return 64'(bus_master_en);
            K_DESC:    return 64'(desc_base[q*PA_W +: PA_W]);
            K_AVAIL:   return 64'(avail_base[q*PA_W +: PA_W]);
            K_USED:    return 64'(used_base[q*PA_W +: PA_W]);
            K_GUEST:   return 64'(guest_features);
            K_CFGWR:   return 64'(cfg_wr);
            K_CFGADDR: return 64'(cfg_addr);
            K_INIT:    return 64'(ring_init);
            default:   return 64'(cfg_rd);
        endcase
    endfunction

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sbq.pop_front();
            act = sample(it.kind, it.q);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic expect_v(string tag, int k, int q, logic [63:0] e);
        item_t it;
        it.tag = tag; it.kind = k; it.q = q; it.exp = e;
        sbq.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [1:0] s, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_size = s; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [1:0] s, logic [31:0] e, string tag);
        bus_rd = 1; bus_addr = a; bus_size = s;
        expect_v(tag, K_RDATA, 0, 64'(e));
        cyc();
        bus_rd = 0;
    endtask

    // Ring expectations from the R6 formulas.
    task automatic expect_ring(int q, logic [31:0] pfn, string tag);
        logic [63:0] d, a, u;
        d = 64'(pfn) << 12;
        a = d + 64'(16 * QSIZE);
        u = ((a + 64'(4 + 2 * QSIZE)) + 64'hFFF) & ~64'hFFF;
        expect_v(tag, K_DESC, q, d);
        expect_v(tag, K_AVAIL, q, a);
        expect_v(tag, K_USED, q, u);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        // R14 reset state
        rd(8'h04, 2, 32'h0, "R14 guest features");
        rd(8'h12, 0, 32'h0, "R14 status");
        rd(8'h0E, 1, 32'h0, "R14 selector");
        expect_v("R14 irq", K_IRQ, 0, 0);
        expect_v("R14 bus master", K_MASTER, 0, 0);
        expect_v("R14 desc q0", K_DESC, 0, 0);
        cyc();
        // R1 / R11
        rd(8'h00, 2, 32'h4100_0021, "R1 host features");
        rd(8'h00, 0, 32'h0000_0021, "R11 byte read");
        rd(8'h02, 2, 32'hFFFF_FFFF, "R11 unmapped word");
        rd(8'h11, 1, 32'h0000_FFFF, "R11 unmapped half");
        // R2 R3 R4 negotiation
        wr(8'h04, 2, 32'h0100_0001);
        expect_v("R2 subset stored", K_GUEST, 0, 64'h0100_0001);
        rd(8'h04, 2, 32'h0100_0001, "R2 readback");
        wr(8'h04, 2, 32'h4000_0002);
        expect_v("R3 fallback", K_GUEST, 0, 64'h1);
        cyc();
        wr(8'h04, 2, 32'h0000_0F23);
        expect_v("R4 masked", K_GUEST, 0, 64'h21);
        cyc();
        // R10 notify before any ring exists
        wr(8'h10, 1, 32'h0);
        expect_v("R10 no ring no notify", K_NOTIFY, 0, 0);
        cyc();
        // R5 selector
        wr(8'h0E, 1, 32'h1);
        rd(8'h0E, 1, 32'h1, "R5 select valid");
        wr(8'h0E, 1, 32'h2);
        rd(8'h0E, 1, 32'h1, "R5 select out of range kept");
        wr(8'h0E, 2, 32'h0001_0000);
        rd(8'h0E, 1, 32'h0, "R5 low 16 bits only");
        wr(8'h0E, 1, 32'h1);
        // R6 ring programming
        wr(8'h08, 2, 32'h1);
        expect_v("R6 init q1", K_INIT, 0, 64'b10);
        expect_ring(1, 32'h1, "R6 bases q1");
        expect_v("R6 q0 untouched", K_DESC, 0, 0);
        rd(8'h08, 2, 32'h1, "R6 pfn readback");
        rd(8'h0C, 1, 32'h100, "R6 queue size");
        wr(8'h0E, 1, 32'h0);
        wr(8'h08, 2, 32'h5);
        expect_v("R6 init q0", K_INIT, 0, 64'b01);
        expect_ring(0, 32'h5, "R6 bases q0");
        cyc();
        // R10 notify
        wr(8'h10, 1, 32'h1);
        expect_v("R10 notify q1", K_NOTIFY, 0, 64'b10);
        cyc();
        wr(8'h10, 1, 32'h0);
        expect_v("R10 notify q0", K_NOTIFY, 0, 64'b01);
        cyc();
        wr(8'h10, 1, 32'h2);
        expect_v("R10 index out of range", K_NOTIFY, 0, 0);
        cyc();
        // R12 device region
        bus_wr = 1; bus_addr = 8'h18; bus_size = 2; bus_wdata = 32'h55;
        expect_v("R12 cfg write strobe", K_CFGWR, 0, 1);
        expect_v("R12 cfg offset", K_CFGADDR, 0, 4);
        cyc();
        bus_wr = 0;
        expect_v("R12 strobe ends", K_CFGWR, 0, 0);
        expect_v("R12 cfg read strobe", K_CFGRD, 0, 1);
        rd(8'h14, 2, 32'hCAFE_0123, "R12 cfg read data");
        // R9 interrupt status
        isr_set = 8'h01; cyc(); isr_set = 8'h00;
        expect_v("R9 irq raised", K_IRQ, 0, 1);
        rd(8'h13, 0, 32'h1, "R9 isr value");
        expect_v("R9 irq dropped", K_IRQ, 0, 0);
        rd(8'h13, 0, 32'h0, "R9 isr cleared");
        // R13 same-cycle read and set
        isr_set = 8'h01; cyc(); isr_set = 8'h00;
        isr_set = 8'h02;
        rd(8'h13, 0, 32'h1, "R13 read returns old byte");
        isr_set = 8'h00;
        expect_v("R13 irq held", K_IRQ, 0, 1);
        rd(8'h13, 0, 32'h2, "R13 new cause kept");
        // R8 status / ready
        wr(8'h12, 0, 32'h04);
        expect_v("R8 ready pulse", K_READY, 0, 1);
        expect_v("R8 bus master on", K_MASTER, 0, 1);
        rd(8'h12, 0, 32'h04, "R8 status readback");
        wr(8'h12, 0, 32'h05);
        expect_v("R8 no pulse when already set", K_READY, 0, 0);
        cyc();
        wr(8'h12, 0, 32'h01);
        wr(8'h12, 0, 32'h05);
        expect_v("R8 pulse after re-arm", K_READY, 0, 1);
        cyc();
        // R7 reset via status zero
        wr(8'h12, 0, 32'h00);
        expect_v("R7 status reset pulse", K_RESET, 0, 1);
        expect_v("R7 guest cleared", K_GUEST, 0, 0);
        expect_v("R7 q0 cleared", K_DESC, 0, 0);
        expect_v("R7 q1 cleared", K_USED, 1, 0);
        expect_v("R7 bus master kept", K_MASTER, 0, 1);
        rd(8'h08, 2, 32'h0, "R7 pfn cleared");
        // R7 reset via zero frame, with pending interrupt
        wr(8'h04, 2, 32'h21);
        wr(8'h0E, 1, 32'h1);
        wr(8'h08, 2, 32'h3);
        expect_ring(1, 32'h3, "R6 bases q1 again");
        isr_set = 8'h04; cyc(); isr_set = 8'h00;
        wr(8'h08, 2, 32'h0);
        expect_v("R7 frame reset pulse", K_RESET, 0, 1);
        expect_v("R7 irq cleared", K_IRQ, 0, 0);
        expect_v("R7 guest cleared by frame", K_GUEST, 0, 0);
        expect_v("R7 q1 desc cleared", K_DESC, 1, 0);
        rd(8'h0E, 1, 32'h0, "R7 selector cleared");
        cyc();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule